// File: doc/BRIEF.md
# Non-Blocking Store Miss Table

This block sits on the requester side of one node in a distributed shared-memory machine that runs under release consistency. It keeps a small table of outstanding line misses so that the processor never waits on a store. A store to a line the node does not hold sends a read-for-ownership request. A store to a line the node holds read-only sends an ownership-upgrade request. In both cases the store is absorbed into the table at once. Each entry remembers which bytes the pending stores wrote, and when the line data finally arrives it lands only underneath those bytes.

An entry finishes its write only when it has seen as many invalidation acknowledgements as the expected count. That count rides on one of the inbound messages and may show up before or after some of the acknowledgements. Load misses to different lines may be outstanding together. A load and a store to the same line share one entry. A fence or release request is granted only while no entry still holds an unfinished write. When an entry completes, the block reports its tag, line and merged data and frees the slot.

Top module: `store_miss_table`

## Requirements
- R1: Once reset is released, `req_ready` is high, `out_valid` and `done_valid` are low, and `fence_ready` follows `fence_req` because the table is empty.
- R2: An accepted miss to a line with no entry is sent on the outbound port in the next cycle. The tag on that request is the lowest free entry index. The kind encoding is: 0 for a load (shared read), 1 for a store with `req_shared` low (read for ownership), 2 for a store with `req_shared` high (upgrade, no line data awaited).
- R3: Byte b of a line is bits [8b+7:8b]. In the completed data, bytes written by the entry's stores hold the store data and every other byte holds the inbound fill. For an upgrade entry that never receives a fill, the unwritten bytes are zero.
- R4: A store to a line whose entry already holds a store is accepted in the same cycle and issues no outbound request. Its bytes are added to the entry's written set, and where bytes overlap the later store wins.
- R5: An entry holding a store does not complete until the expected count has arrived (`in_has_cnt`) and the number of acknowledgements received (`in_is_ack`) equals it. Acknowledgements may come before or after the count, and one message may carry both.
- R6: Several load misses to distinct lines can be outstanding at once. Fills may return in any order, and each entry completes on its own.
- R7: A store to a line that has a load-only entry merges into that entry. It issues a kind-2 request carrying that entry's tag, and the entry then needs both its fill and the acknowledgement count.
- R8: One cycle after the message that completes an entry, `done_valid` pulses with that entry's tag, line and merged data, and the slot becomes free.
- R9: `fence_ready` is high only while `fence_req` is high and no entry has an incomplete write. Load-only entries do not hold a fence off.
- R10: While every entry is in use, a miss to a new line sees `req_ready` low. A request to a line that already has an entry is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor miss request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_shared | input | 1 | Store targets a line held read-only |
| req_line | input | LINE_W | Line address |
| req_be | input | LINE_BYTES | Bytes written by a store |
| req_wdata | input | 8*LINE_BYTES | Store data, byte lanes |
| out_valid | output | 1 | Outbound coherence request |
| out_kind | output | 2 | 0 read, 1 read for ownership, 2 upgrade |
| out_line | output | LINE_W | Line of the outbound request |
| out_tag | output | log2(ENTRIES) | Entry index the replies must carry |
| in_valid | input | 1 | Inbound reply or acknowledgement |
| in_tag | input | log2(ENTRIES) | Entry addressed by the inbound message |
| in_has_data | input | 1 | Message carries line data |
| in_data | input | 8*LINE_BYTES | Line data |
| in_is_ack | input | 1 | Message counts as one invalidation acknowledgement |
| in_has_cnt | input | 1 | Message carries the expected acknowledgement count |
| in_cnt | input | CNT_W | Expected acknowledgement count |
| done_valid | output | 1 | An entry completed |
| done_tag | output | log2(ENTRIES) | Tag of the completed entry |
| done_line | output | LINE_W | Line of the completed entry |
| done_data | output | 8*LINE_BYTES | Merged line data |
| fence_req | input | 1 | Fence or release wants to proceed |
| fence_ready | output | 1 | Fence may proceed |

## Verification
The bench aims at the byte merge first. It uses masks that are empty, full and alternating, and it stacks two overlapping stores on one line, because a design that let the fill win or that forgot the earlier mask would report wrong bytes. It delivers acknowledgements both ahead of the count and together with it. A design with an unsigned counter, or one that treated the count message as the finishing event, would then complete too early or never. It also drives a store into a pending load entry, where a design might allocate a second entry or skip the upgrade. Finally it fills the table and shows that a same-line store still gets through while a new line is refused.

// File: rtl/smt_pkg.sv
package smt_pkg;

    typedef enum logic [1:0] {
        KIND_READ      = 2'd0,
        KIND_READ_EXCL = 2'd1,
        KIND_UPGRADE   = 2'd2
    } out_kind_e;

endpackage

// File: rtl/smt_pick.sv
module smt_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/smt_lookup.sv
module smt_lookup #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 16
) (
    input  logic [ENTRIES-1:0]             vld,
    input  logic [ENTRIES-1:0][LINE_W-1:0] lines,
    input  logic [LINE_W-1:0]              key,
    output logic [ENTRIES-1:0]             hit
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit[g] = vld[g] && (lines[g] == key);
    end

endmodule

// File: rtl/store_miss_table.sv
module store_miss_table
    import smt_pkg::*;
#(
    parameter int ENTRIES    = 4,
    parameter int LINE_W     = 16,
    parameter int LINE_BYTES = 4,
    parameter int CNT_W      = 4,
    localparam int DATA_W    = LINE_BYTES * 8,
    localparam int TAG_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int BAL_W     = CNT_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_store,
    input  logic                  req_shared,
    input  logic [LINE_W-1:0]     req_line,
    input  logic [LINE_BYTES-1:0] req_be,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  out_valid,
    output logic [1:0]            out_kind,
    output logic [LINE_W-1:0]     out_line,
    output logic [TAG_W-1:0]      out_tag,
    input  logic                  in_valid,
    input  logic [TAG_W-1:0]      in_tag,
    input  logic                  in_has_data,
    input  logic [DATA_W-1:0]     in_data,
    input  logic                  in_is_ack,
    input  logic                  in_has_cnt,
    input  logic [CNT_W-1:0]      in_cnt,
    output logic                  done_valid,
    output logic [TAG_W-1:0]      done_tag,
    output logic [LINE_W-1:0]     done_line,
    output logic [DATA_W-1:0]     done_data,
    input  logic                  fence_req,
    output logic                  fence_ready
);

    typedef struct packed {
        logic                    vld;
        logic [LINE_W-1:0]       line;
        logic                    wr;
        logic                    fill_need;
        logic [LINE_BYTES-1:0]   mask;
        logic [DATA_W-1:0]       data;
        logic                    cnt_known;
        logic signed [BAL_W-1:0] bal;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
        logic               out_v;
        logic [1:0]         out_k;
        logic [LINE_W-1:0]  out_line;
        logic [TAG_W-1:0]   out_tag;
        logic               done_v;
        logic [TAG_W-1:0]   done_tag;
        logic [LINE_W-1:0]  done_line;
        logic [DATA_W-1:0]  done_data;
    } st_t;

    st_t st_q, st_d;

    logic [ENTRIES-1:0]             vld_vec, free_vec, hit_vec, cmp_vec, wr_vec;
    logic [ENTRIES-1:0][LINE_W-1:0] line_vec;
    logic                           free_any, ret_any, hit_any;
    logic [TAG_W-1:0]               free_idx, ret_idx, hit_idx;
    logic                           ret_blocks, accept;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            vld_vec[i]  = st_q.ent[i].vld;
            line_vec[i] = st_q.ent[i].line;
            free_vec[i] = !st_q.ent[i].vld;
            wr_vec[i]   = st_q.ent[i].vld && st_q.ent[i].wr;
            cmp_vec[i]  = st_q.ent[i].vld && !st_q.ent[i].fill_need &&
                          (!st_q.ent[i].wr ||
                           (st_q.ent[i].cnt_known && st_q.ent[i].bal == '0));
        end
    end

    smt_lookup #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_lookup (
        .vld(vld_vec), .lines(line_vec), .key(req_line), .hit(hit_vec)
    );

    smt_pick #(.N(ENTRIES)) u_pick_free (.vec(free_vec), .any(free_any), .idx(free_idx));
    smt_pick #(.N(ENTRIES)) u_pick_ret  (.vec(cmp_vec),  .any(ret_any),  .idx(ret_idx));
    smt_pick #(.N(ENTRIES)) u_pick_hit  (.vec(hit_vec),  .any(hit_any),  .idx(hit_idx));

    // A request to the line that retires this cycle waits one cycle.
    assign ret_blocks  = ret_any && hit_vec[ret_idx];
    assign req_ready   = !ret_blocks && (hit_any || free_any);
    assign accept      = req_valid && req_ready;
    assign fence_ready = fence_req && !(|wr_vec);

    always_comb begin
        st_d        = st_q;
        st_d.out_v  = 1'b0;
        st_d.done_v = 1'b0;

        // Retire the lowest complete entry.
        if (ret_any) begin
            st_d.done_v             = 1'b1;
            st_d.done_tag           = ret_idx;
            st_d.done_line          = st_q.ent[ret_idx].line;
            st_d.done_data          = st_q.ent[ret_idx].data;
            st_d.ent[ret_idx].vld   = 1'b0;
        end

        // Inbound fill, count and acknowledgement.
        for (int i = 0; i < ENTRIES; i++) begin
            if (in_valid && in_tag == TAG_W'(i) && st_q.ent[i].vld) begin
                if (in_has_data && st_q.ent[i].fill_need) begin
                    for (int b = 0; b < LINE_BYTES; b++) begin
                        if (!st_q.ent[i].mask[b])
                            st_d.ent[i].data[b*8 +: 8] = in_data[b*8 +: 8];
                    end
                    st_d.ent[i].fill_need = 1'b0;
                end
                if (in_has_cnt) begin
                    st_d.ent[i].cnt_known = 1'b1;
                    st_d.ent[i].bal = st_d.ent[i].bal - $signed({2'b00, in_cnt});
                end
                if (in_is_ack) begin
                    st_d.ent[i].bal = st_d.ent[i].bal + BAL_W'(1);
                end
            end
        end

        // Processor request: merge into an entry or allocate one.
        if (accept) begin
            if (hit_any) begin
                if (req_store) begin
                    if (!st_q.ent[hit_idx].wr) begin
                        st_d.out_v    = 1'b1;
                        st_d.out_k    = KIND_UPGRADE;
                        st_d.out_line = req_line;
                        st_d.out_tag  = hit_idx;
                    end
                    st_d.ent[hit_idx].wr   = 1'b1;
                    st_d.ent[hit_idx].mask = st_q.ent[hit_idx].mask | req_be;
                    for (int b = 0; b < LINE_BYTES; b++) begin
                        if (req_be[b])
                            st_d.ent[hit_idx].data[b*8 +: 8] = req_wdata[b*8 +: 8];
                    end
                end
            end else begin
                st_d.ent[free_idx]           = '0;
                st_d.ent[free_idx].vld       = 1'b1;
                st_d.ent[free_idx].line      = req_line;
                st_d.ent[free_idx].wr        = req_store;
                st_d.ent[free_idx].fill_need = !(req_store && req_shared);
                if (req_store) begin
                    st_d.ent[free_idx].mask = req_be;
                    for (int b = 0; b < LINE_BYTES; b++) begin
                        if (req_be[b])
                            st_d.ent[free_idx].data[b*8 +: 8] = req_wdata[b*8 +: 8];
                    end
                end
                st_d.out_v    = 1'b1;
                st_d.out_k    = !req_store ? KIND_READ :
                                (req_shared ? KIND_UPGRADE : KIND_READ_EXCL);
                st_d.out_line = req_line;
                st_d.out_tag  = free_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.out_v;
    assign out_kind   = st_q.out_k;
    assign out_line   = st_q.out_line;
    assign out_tag    = st_q.out_tag;
    assign done_valid = st_q.done_v;
    assign done_tag   = st_q.done_tag;
    assign done_line  = st_q.done_line;
    assign done_data  = st_q.done_data;

    AST_NEW_LINE_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !hit_any) |=> (out_valid && out_line == $past(req_line))); // R2

    AST_STORE_MERGE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_store && hit_any && st_q.ent[hit_idx].wr) |=> !out_valid); // R4

    AST_LINE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R7

    AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !st_q.ent[done_tag].vld); // R8

    AST_STORE_HOLDS_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_store) |=> !fence_ready); // R9

endmodule

// File: tb/sim_store_miss_table.sv
module sim_store_miss_table;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_store, req_shared;
    logic [15:0] req_line;
    logic [3:0]  req_be;
    logic [31:0] req_wdata;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [15:0] out_line;
    logic [1:0]  out_tag;
    logic        in_valid;
    logic [1:0]  in_tag;
    logic        in_has_data;
    logic [31:0] in_data;
    logic        in_is_ack, in_has_cnt;
    logic [3:0]  in_cnt;
    logic        done_valid;
    logic [1:0]  done_tag;
    logic [15:0] done_line;
    logic [31:0] done_data;
    logic        fence_req, fence_ready;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    store_miss_table u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_shared(req_shared), .req_line(req_line), .req_be(req_be), .req_wdata(req_wdata),
        .out_valid(out_valid), .out_kind(out_kind), .out_line(out_line), .out_tag(out_tag),
        .in_valid(in_valid), .in_tag(in_tag), .in_has_data(in_has_data), .in_data(in_data),
        .in_is_ack(in_is_ack), .in_has_cnt(in_has_cnt), .in_cnt(in_cnt),
        .done_valid(done_valid), .done_tag(done_tag), .done_line(done_line), .done_data(done_data),
        .fence_req(fence_req), .fence_ready(fence_ready)
    );

    // {be[3:0], store data, fill data, expected merged line}
    localparam logic [99:0] VEC [0:3] = '{
        100'h0_00000000_A1B2C3D4_A1B2C3D4,
        100'hF_11223344_FFFFFFFF_11223344,
        100'h5_55667788_AABBCCDD_AA66CC88,
        100'hA_01020304_F0E0D0C0_01E003C0
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic send_req(input logic st, input logic sh, input logic [15:0] ln,
                            input logic [3:0] be, input logic [31:0] wd);
        req_valid = 1'b1; req_store = st; req_shared = sh;
        req_line = ln; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_store = 1'b0; req_shared = 1'b0;
        req_be = '0; req_wdata = '0;
    endtask

    task automatic send_in(input logic [1:0] tg, input logic hd, input logic [31:0] d,
                           input logic ak, input logic hc, input logic [3:0] c);
        in_valid = 1'b1; in_tag = tg; in_has_data = hd; in_data = d;
        in_is_ack = ak; in_has_cnt = hc; in_cnt = c;
        @(negedge clk);
        in_valid = 1'b0; in_has_data = 1'b0; in_is_ack = 1'b0; in_has_cnt = 1'b0;
        in_data = '0; in_cnt = '0;
    endtask

    task automatic chk_out(input string r, input logic [1:0] kind, input logic [1:0] tag,
                           input logic [15:0] ln);
        chk({r, " out_valid"}, 32'(out_valid), 32'd1);
        chk({r, " out_kind"},  32'(out_kind),  32'(kind));
        chk({r, " out_tag"},   32'(out_tag),   32'(tag));
        chk({r, " out_line"},  32'(out_line),  32'(ln));
    endtask

    task automatic chk_done(input string r, input logic [1:0] tag, input logic [15:0] ln,
                            input logic [31:0] d);
        chk({r, " done_valid"}, 32'(done_valid), 32'd1);
        chk({r, " done_tag"},   32'(done_tag),   32'(tag));
        chk({r, " done_line"},  32'(done_line),  32'(ln));
        chk({r, " done_data"},  done_data,       d);
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 0; req_store = 0; req_shared = 0; req_line = '0; req_be = '0; req_wdata = '0;
        in_valid = 0; in_tag = '0; in_has_data = 0; in_data = '0; in_is_ack = 0;
        in_has_cnt = 0; in_cnt = '0; fence_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        fence_req = 1'b1;
        #1;
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 done_valid", 32'(done_valid), 32'd0);
        chk("R1 fence_ready", 32'(fence_ready), 32'd1);
        fence_req = 1'b0;
        #1;
        chk("R9 fence_ready without request", 32'(fence_ready), 32'd0);
        @(negedge clk);

        // R3: byte merge vectors, one store miss and one fill each
        for (int k = 0; k < 4; k++) begin
            send_req(1'b1, 1'b0, 16'h0100 + 16'(k), VEC[k][99:96], VEC[k][95:64]);
            chk_out("R2 read-excl", 2'd1, 2'd0, 16'h0100 + 16'(k));
            send_in(2'd0, 1'b1, VEC[k][63:32], 1'b0, 1'b1, 4'd0);
            @(negedge clk);
            chk_done("R3 merge", 2'd0, 16'h0100 + 16'(k), VEC[k][31:0]);
        end

        // R5: upgrade, acknowledgements ahead of the count
        send_req(1'b1, 1'b1, 16'h0020, 4'b0001, 32'h000000EE);
        chk_out("R2 upgrade", 2'd2, 2'd0, 16'h0020);
        fence_req = 1'b1;
        #1;
        chk("R9 fence held", 32'(fence_ready), 32'd0);
        send_in(2'd0, 1'b0, '0, 1'b1, 1'b0, 4'd0);
        @(negedge clk);
        chk("R5 one ack no count", 32'(done_valid), 32'd0);
        send_in(2'd0, 1'b0, '0, 1'b1, 1'b0, 4'd0);
        @(negedge clk);
        chk("R5 two acks no count", 32'(done_valid), 32'd0);
        send_in(2'd0, 1'b0, '0, 1'b1, 1'b1, 4'd3);
        @(negedge clk);
        chk_done("R8 upgrade done", 2'd0, 16'h0020, 32'h000000EE);
        chk("R9 fence released", 32'(fence_ready), 32'd1);

        // R5: count first, then acknowledgements
        send_req(1'b1, 1'b1, 16'h0021, 4'b0010, 32'h0000CD00);
        chk_out("R2 upgrade 2", 2'd2, 2'd0, 16'h0021);
        send_in(2'd0, 1'b0, '0, 1'b0, 1'b1, 4'd2);
        @(negedge clk);
        chk("R5 count only", 32'(done_valid), 32'd0);
        send_in(2'd0, 1'b0, '0, 1'b1, 1'b0, 4'd0);
        @(negedge clk);
        chk("R5 one of two acks", 32'(done_valid), 32'd0);
        send_in(2'd0, 1'b0, '0, 1'b1, 1'b0, 4'd0);
        @(negedge clk);
        chk_done("R5 count first done", 2'd0, 16'h0021, 32'h0000CD00);
        fence_req = 1'b0;

        // R4: second store onto a pending store line
        send_req(1'b1, 1'b0, 16'h0030, 4'b0011, 32'h0000BBAA);
        chk_out("R4 first store", 2'd1, 2'd0, 16'h0030);
        send_req(1'b1, 1'b0, 16'h0030, 4'b0110, 32'h00CCDD00);
        chk("R4 no second request", 32'(out_valid), 32'd0);
        send_in(2'd0, 1'b1, 32'h44332211, 1'b0, 1'b1, 4'd0);
        @(negedge clk);
        chk_done("R4 union of masks", 2'd0, 16'h0030, 32'h44CCDDAA);

        // R6: three outstanding loads, fills out of order
        send_req(1'b0, 1'b0, 16'h0040, 4'b0000, 32'h0);
        chk_out("R6 load a", 2'd0, 2'd0, 16'h0040);
        send_req(1'b0, 1'b0, 16'h0041, 4'b0000, 32'h0);
        chk_out("R6 load b", 2'd0, 2'd1, 16'h0041);
        send_req(1'b0, 1'b0, 16'h0042, 4'b0000, 32'h0);
        chk_out("R6 load c", 2'd0, 2'd2, 16'h0042);
        fence_req = 1'b1;
        #1;
        chk("R9 loads do not hold fence", 32'(fence_ready), 32'd1);
        fence_req = 1'b0;
        send_in(2'd2, 1'b1, 32'h22222222, 1'b0, 1'b0, 4'd0);
        @(negedge clk);
        chk_done("R6 fill c", 2'd2, 16'h0042, 32'h22222222);
        send_in(2'd0, 1'b1, 32'h00000011, 1'b0, 1'b0, 4'd0);
        @(negedge clk);
        chk_done("R6 fill a", 2'd0, 16'h0040, 32'h00000011);
        send_in(2'd1, 1'b1, 32'h12121212, 1'b0, 1'b0, 4'd0);
        @(negedge clk);
        chk_done("R6 fill b", 2'd1, 16'h0041, 32'h12121212);

        // R7: store joins a pending load entry
        send_req(1'b0, 1'b0, 16'h0050, 4'b0000, 32'h0);
        chk_out("R7 load", 2'd0, 2'd0, 16'h0050);
        send_req(1'b1, 1'b0, 16'h0050, 4'b1000, 32'h99000000);
        chk_out("R7 upgrade on merge", 2'd2, 2'd0, 16'h0050);
        send_in(2'd0, 1'b1, 32'h12345678, 1'b0, 1'b0, 4'd0);
        @(negedge clk);
        chk("R7 fill alone not enough", 32'(done_valid), 32'd0);
        send_in(2'd0, 1'b0, '0, 1'b1, 1'b1, 4'd1);
        @(negedge clk);
        chk_done("R7 merged done", 2'd0, 16'h0050, 32'h99345678);

        // R10: full table
        for (int k = 0; k < 4; k++) begin
            send_req(1'b0, 1'b0, 16'h0060 + 16'(k), 4'b0000, 32'h0);
            chk_out("R10 fill table", 2'd0, 2'(k), 16'h0060 + 16'(k));
        end
        req_valid = 1'b1; req_store = 1'b0; req_line = 16'h0064;
        #1;
        chk("R10 new line stalls", 32'(req_ready), 32'd0);
        req_store = 1'b1; req_line = 16'h0062; req_be = 4'b0001; req_wdata = 32'h00000077;
        #1;
        chk("R10 same line accepted", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0; req_store = 1'b0; req_be = '0; req_wdata = '0;
        chk_out("R10 store into full table", 2'd2, 2'd2, 16'h0062);
        send_in(2'd0, 1'b1, 32'hABCDABCD, 1'b0, 1'b0, 4'd0);
        @(negedge clk);
        chk_done("R10 slot freed", 2'd0, 16'h0060, 32'hABCDABCD);
        send_req(1'b0, 1'b0, 16'h0064, 4'b0000, 32'h0);
        chk_out("R10 reuse freed slot", 2'd0, 2'd0, 16'h0064);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule